// File: doc/BRIEF.md
# Channel-Tagged Sample Buffer with Half-Level Interrupt

This block sits between an acquisition scan sequencer and a host register bus. Every conversion result arrives as a 16-bit word. The channel tag sits in bits 3:0 and the 12-bit sample sits in bits 15:4. The block stores these words in a 1024-deep first-in first-out buffer. The host controls the block through five byte-wide register offsets. One turns capture on or off. One empties the buffer. One acknowledges the interrupt. Two return the oldest word one byte at a time. One returns a status byte.

The interrupt rises when the fill level climbs to half capacity (512 words). The host can then drain a full block of 512 words in one burst. Reading the low byte copies the oldest word into a hold register and does not remove it. Reading the high byte returns the upper half of that copy and removes the word. A word that arrives while the buffer is full is discarded, and a sticky overflow flag records the loss.

Top module: `tagged_sample_fifo`

## Requirements
- R1: After reset, the status byte reads 0x01 (empty), the interrupt is low and capture is off.
- R2: While capture is off, an incoming word is not stored. Capture is turned on by writing the value 1 to offset 6, and any other value written there turns it off.
- R3: Words leave in arrival order. A read at offset 23 returns bits 7:0 of the oldest word. A following read at offset 24 returns bits 15:8 of that same word and removes it.
- R4: A read at offset 23 never removes a word. Repeated reads at 23 return the same byte and leave the fill level unchanged.
- R5: The status byte at offset 25 carries the empty flag in bit 0, the flag for a fill level of 512 or more in bit 1, and the overflow flag in bit 2. Bits 7:3 read 0. Once set, the overflow flag stays set until a flush.
- R6: The interrupt rises one cycle after the fill level reaches 512. It stays high until the host writes any value to offset 20.
- R7: After the interrupt is cleared, it does not rise again while the level stays at or above 512. It rises again only after the level falls below 512 and then climbs back to 512.
- R8: A word that arrives while 1024 words are held is dropped and sets the overflow flag. The stored words stay intact and in order.
- R9: Writing any value to offset 25 empties the buffer, clears the overflow flag and drops the interrupt. Later words are stored from a fresh start.
- R10: Read data appears on the data output on the clock edge that samples the read strobe, and it holds its value until the next read.
- R11: A read at offset 23 while the buffer is empty returns 0x00 and loads zero into the hold register, so a following read at 24 also returns 0x00 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Incoming conversion word is valid this cycle |
| smp_word | input | 16 | Conversion word: sample in 15:4, channel tag in 3:0 |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Half-level interrupt, level until cleared |

## Verification
A stored word, a pop and a flush all show up in the status byte on the same edge that samples the strobe. The bench therefore reads status in the next register access. Read data is registered, so the bench drives each strobe at a falling edge and samples the data at the following falling edge, which is one rising edge later. The interrupt lags the level by one further register. After the push that reaches 512 words, the bench waits one extra cycle before it samples the interrupt. A clear or flush takes effect on the edge that samples the write, so the interrupt is checked right after that access.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    // host register offsets
    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 5'd6;
    localparam logic [ADDR_W-1:0] OFS_IRQ_CLR = 5'd20;
    localparam logic [ADDR_W-1:0] OFS_DATA_LO = 5'd23;
    localparam logic [ADDR_W-1:0] OFS_DATA_HI = 5'd24;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 5'd25;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_LO,
        OP_RD_HI,
        OP_RD_STAT,
        OP_RD_OTHER,
        OP_WR_ENABLE,
        OP_WR_CLR,
        OP_WR_FLUSH
    } bus_op_e;

    typedef struct packed {
        logic [4:0] spare;
        logic       ovf;
        logic       half;
        logic       empty;
    } fifo_stat_t;

    function automatic bus_op_e decode_op(input logic rd, input logic wr,
                                          input logic [ADDR_W-1:0] a);
        bus_op_e op;
        op = OP_NONE;
        if (rd) begin
            case (a)
                OFS_DATA_LO: op = OP_RD_LO;
                OFS_DATA_HI: op = OP_RD_HI;
                OFS_STATUS:  op = OP_RD_STAT;
                default:     op = OP_RD_OTHER;
            endcase
        end else if (wr) begin
            case (a)
                OFS_ENABLE:  op = OP_WR_ENABLE;
                OFS_IRQ_CLR: op = OP_WR_CLR;
                OFS_STATUS:  op = OP_WR_FLUSH;
                default:     op = OP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              push_req_i,
    input  logic [WORD_W-1:0] push_word_i,
    input  logic              pop_req_i,
    input  logic              flush_i,
    output logic [WORD_W-1:0] head_word_o,
    output logic              empty_o,
    output logic              half_o,
    output logic              ovf_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              ovf;
    logic              full, do_push, do_pop, drop;

    assign full    = (cnt == FULL_LVL);
    assign empty_o = (cnt == '0);
    assign half_o  = (cnt >= HALF_LVL);
    assign ovf_o   = ovf;

    assign do_push = push_req_i && en_i && !full && !flush_i;
    assign drop    = push_req_i && en_i && full && !flush_i;
    assign do_pop  = pop_req_i && !empty_o && !flush_i;

    assign head_word_o = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word_i;
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (drop)    ovf    <= 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push_req_i && en_i && !flush_i) |=> (ovf && cnt == FULL_LVL));

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !flush_i) |=> ovf);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (cnt == '0 && !ovf));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !pop_req_i && !flush_i) |=> $stable(cnt));

endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq (
    input  logic clk,
    input  logic rst,
    input  logic half_i,
    input  logic clr_i,
    input  logic flush_i,
    output logic irq_o
);
    logic half_d;
    logic irq_q;

    assign irq_o = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_d <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            half_d <= half_i;
            if (flush_i)                irq_q <= 1'b0;
            else if (half_i && !half_d) irq_q <= 1'b1;
            else if (clr_i)             irq_q <= 1'b0;
        end
    end

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(half_i) && !flush_i) |=> irq_o);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(half_i) && !$past(half_d)));

    // R9
    irq_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !irq_o);

endmodule

// File: rtl/sfifo_regport.sv
module sfifo_regport
    import sfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] head_word_i,
    input  fifo_stat_t        stat_i,
    output logic              en_o,
    output logic              flush_o,
    output logic              clr_o,
    output logic              pop_o,
    output logic [BYTE_W-1:0] bus_rdata
);
    bus_op_e           op;
    logic              en_q;
    logic [WORD_W-1:0] hold_q;
    logic [BYTE_W-1:0] rdata_q;

    assign op        = decode_op(bus_rd, bus_wr, bus_addr);
    assign en_o      = en_q;
    assign flush_o   = (op == OP_WR_FLUSH);
    assign clr_o     = (op == OP_WR_CLR);
    assign pop_o     = (op == OP_RD_HI);
    assign bus_rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            hold_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (op)
                OP_WR_ENABLE: en_q <= (bus_wdata == 8'd1);
                OP_RD_LO: begin
                    if (stat_i.empty) begin
                        hold_q  <= '0;
                        rdata_q <= '0;
                    end else begin
                        hold_q  <= head_word_i;
                        rdata_q <= head_word_i[BYTE_W-1:0];
                    end
                end
                OP_RD_HI:    rdata_q <= hold_q[WORD_W-1:BYTE_W];
                OP_RD_STAT:  rdata_q <= stat_i;
                OP_RD_OTHER: rdata_q <= '0;
                default: ;
            endcase
        end
    end

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/tagged_sample_fifo.sv
module tagged_sample_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_valid,
    input  logic [15:0] smp_word,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq
);
    logic              en, flush, clr, pop;
    logic              empty, half, ovf;
    logic [WORD_W-1:0] head_word;
    fifo_stat_t        stat;

    always_comb begin
        stat       = '0;
        stat.empty = empty;
        stat.half  = half;
        stat.ovf   = ovf;
    end

    sfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en),
        .push_req_i  (smp_valid),
        .push_word_i (smp_word),
        .pop_req_i   (pop),
        .flush_i     (flush),
        .head_word_o (head_word),
        .empty_o     (empty),
        .half_o      (half),
        .ovf_o       (ovf)
    );

    sfifo_regport u_port (
        .clk         (clk),
        .rst         (rst),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .head_word_i (head_word),
        .stat_i      (stat),
        .en_o        (en),
        .flush_o     (flush),
        .clr_o       (clr),
        .pop_o       (pop),
        .bus_rdata   (bus_rdata)
    );

    sfifo_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .half_i  (half),
        .clr_i   (clr),
        .flush_i (flush),
        .irq_o   (irq)
    );

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !smp_valid) |=> empty);

endmodule

// File: tb/sim_tagged_sample_fifo.sv
module sim_tagged_sample_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_word = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [15:0] model[$];
    logic [11:0] seq = '0;

    localparam logic [4:0] A_EN = 5'd6, A_CLR = 5'd20, A_LO = 5'd23,
                           A_HI = 5'd24, A_ST = 5'd25;

    // word, expected low byte, expected high byte
    localparam logic [31:0] VEC [6] = '{
        {16'hABC5, 8'hC5, 8'hAB},
        {16'h0010, 8'h10, 8'h00},
        {16'hFFFF, 8'hFF, 8'hFF},
        {16'h800F, 8'h0F, 8'h80},
        {16'h7FF3, 8'hF3, 8'h7F},
        {16'h1239, 8'h39, 8'h12}
    };

    always #2.5 clk = ~clk;

    tagged_sample_fifo u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_word(smp_word),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w, input bit keep);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_word  = w;
        @(negedge clk);
        smp_valid = 1'b0;
        if (keep) model.push_back(w);
    endtask

    task automatic push_burst(input int n, input bit keep);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1;
            smp_word  = {seq, seq[3:0]};
            if (keep) model.push_back({seq, seq[3:0]});
            seq = seq + 1'b1;
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pop_check(input string req);
        logic [7:0] lo, hi;
        logic [15:0] e;
        e = model.pop_front();
        bus_read(A_LO, lo);
        bus_read(A_HI, hi);
        check(req, {hi, lo}, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(A_ST, d); check("R1 status", 16'(d), 16'h01);
        check("R1 irq", 16'(irq), 16'h0);

        // R2 capture off ignores words
        push(16'h1234, 1'b0);
        bus_read(A_ST, d); check("R2 disabled push", 16'(d), 16'h01);
        bus_write(A_EN, 8'h03);
        push(16'h4321, 1'b0);
        bus_read(A_ST, d); check("R2 non-one value disables", 16'(d), 16'h01);
        bus_write(A_EN, 8'h01);

        // R3 table of vectors
        for (int i = 0; i < 6; i++) push(VEC[i][31:16], 1'b0);
        for (int i = 0; i < 6; i++) begin
            bus_read(A_LO, d); check("R3 low byte", 16'(d), 16'(VEC[i][15:8]));
            bus_read(A_HI, d); check("R3 high byte", 16'(d), 16'(VEC[i][7:0]));
        end
        bus_read(A_ST, d); check("R3 drained", 16'(d), 16'h01);

        // R4 low read does not pop
        push(16'h5A3C, 1'b0);
        bus_read(A_LO, d); check("R4 first low", 16'(d), 16'h3C);
        bus_read(A_LO, d); check("R4 repeat low", 16'(d), 16'h3C);
        bus_read(A_ST, d); check("R4 still held", 16'(d), 16'h00);
        bus_read(A_HI, d); check("R4 high", 16'(d), 16'h5A);
        bus_read(A_ST, d); check("R4 popped", 16'(d), 16'h01);

        // R11 empty reads
        bus_read(A_LO, d); check("R11 empty low", 16'(d), 16'h00);
        bus_read(A_HI, d); check("R11 empty high", 16'(d), 16'h00);
        bus_read(A_ST, d); check("R11 stays empty", 16'(d), 16'h01);

        // R6 half-level interrupt
        push_burst(511, 1'b1);
        @(negedge clk);
        check("R6 no irq at 511", 16'(irq), 16'h0);
        bus_read(A_ST, d); check("R5 status at 511", 16'(d), 16'h00);
        push_burst(1, 1'b1);
        @(negedge clk);
        check("R6 irq at 512", 16'(irq), 16'h1);
        bus_read(A_ST, d); check("R5 status at 512", 16'(d), 16'h02);
        repeat (5) @(negedge clk);
        check("R6 irq holds", 16'(irq), 16'h1);
        bus_write(A_CLR, 8'h00);
        check("R6 irq cleared", 16'(irq), 16'h0);

        // R7 re-arm only after falling below half
        push_burst(1, 1'b1);
        @(negedge clk);
        check("R7 no re-fire above half", 16'(irq), 16'h0);
        pop_check("R7 pop order a");
        pop_check("R7 pop order b");
        push_burst(1, 1'b1);
        @(negedge clk);
        check("R7 re-fire on recross", 16'(irq), 16'h1);
        bus_write(A_CLR, 8'h00);

        // R8 overflow at full
        push_burst(512, 1'b1);
        bus_read(A_ST, d); check("R8 full no ovf", 16'(d), 16'h02);
        push_burst(1, 1'b0);
        bus_read(A_ST, d); check("R8 ovf set", 16'(d), 16'h06);
        pop_check("R8 data intact");
        bus_read(A_ST, d); check("R5 ovf sticky", 16'(d), 16'h06);
        check("R7 irq quiet while high", 16'(irq), 16'h0);

        // R9 flush
        bus_write(A_ST, 8'h00);
        model.delete();
        bus_read(A_ST, d); check("R9 flushed", 16'(d), 16'h01);
        check("R9 irq low", 16'(irq), 16'h0);
        push(16'hBEEF, 1'b1);
        pop_check("R9 fresh word");

        // R10 read data holds
        repeat (4) @(negedge clk);
        check("R10 rdata hold", 16'(bus_rdata), 16'hBE);

        // R2 turning capture off
        bus_write(A_EN, 8'h00);
        push(16'h7777, 1'b0);
        bus_read(A_ST, d); check("R2 off again", 16'(d), 16'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule